// File: doc/BRIEF.md
# ADC Channel Sequencer Controller

This block steps the input multiplexer of a dual-channel sampling converter through a programmed list of up to four channel pairs. A 16-bit configuration word holds three things: how many slots the list has, which pair each slot selects, and how conversions are triggered and how BUSY behaves. The list is used only while the converter works in pseudo-differential mode (`pseudo_diff` high). Otherwise, or when the length field is zero, the block falls back to single-channel operation.

The host strobes `conv_start`. The block then issues a one-clock `conv_req` to the converter for each slot and holds `mux_sel` steady while that conversion runs. It waits for the converter's `conv_done` pulse before moving on. In the per-slot trigger mode, every slot needs its own start strobe. In the two single-trigger modes, one strobe runs the whole list, and BUSY either marks each conversion separately or stays high across the whole list. After the last slot, `seq_done` pulses and the list restarts at slot 0.

All pins are plain control and status strobes. No data stream passes through the block, so it has no valid/ready handshake and no back-pressure.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset the configuration word is 0000h, `conv_req`, `busy` and `seq_done` are low, and `mux_sel` is 00.
- R2: Bits [13:12] give the list length: 01 means 2 slots, 10 means 3 and 11 means 4. When the field is 00, or `pseudo_diff` is low, the block is in single-channel mode. In that mode every accepted start gives one conversion, `mux_sel` shows the code in bits [11:10], and `seq_done` never pulses.
- R3: The slot codes sit at bits [11:10] for slot 0, [9:8] for slot 1, [7:6] for slot 2 and [5:4] for slot 3. Code 00 selects pair 0, 01 pair 1, 10 pair 2 and 11 pair 3. `mux_sel` shows the current slot's code from its request cycle until that slot's `conv_done`.
- R4: `conv_req` is a one-clock pulse in the cycle after the edge that accepts `conv_start`.
- R5: When bits [15:14] are 0x, each slot needs its own `conv_start`. `busy` is high from the cycle after `conv_req` through the cycle in which `conv_done` is high.
- R6: When bits [15:14] are 10, one start runs the whole list. The next slot's `conv_req` comes one clock after the previous `conv_done`, and `busy` is low only during those request cycles.
- R7: When bits [15:14] are 11, one start runs the whole list. `busy` stays high from the cycle after the first `conv_req` until the last slot's `conv_done` cycle.
- R8: `seq_done` pulses for one clock in the cycle after the last slot's `conv_done`. The slot index then returns to 0, so `mux_sel` shows the slot 0 code.
- R9: A `conv_start` that arrives while a conversion or a single-trigger list is running is ignored.
- R10: A configuration write is ignored unless the block is idle at slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pseudo_diff | input | 1 | High when the converter is in pseudo-differential mode |
| cfg_wr | input | 1 | Write strobe for the configuration word |
| cfg_data | input | 16 | Configuration word |
| conv_start | input | 1 | Host convert-start strobe |
| conv_done | input | 1 | One-clock end-of-conversion pulse from the converter |
| mux_sel | output | 2 | Channel-pair select for the input multiplexer |
| conv_req | output | 1 | One-clock conversion request |
| busy | output | 1 | Conversion activity indicator |
| seq_done | output | 1 | One-clock end-of-list flag |

## Verification
The converter stub answers each `conv_req` exactly three clocks later. Take the start edge as cycle 0. Slot i's request is then due in cycle 1+4i, its BUSY window covers cycles 2+4i to 4+4i, and `seq_done` is due in cycle 4n+1 for an n-slot list. The bench drives inputs and samples outputs on falling edges. For each cycle it records the outputs and compares them with a trace built from these formulas. Stray starts and configuration writes are placed at known cycles, and the trace must show that they had no effect.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int CFG_W     = 16;
  localparam int SLOT_MAX  = 4;
  localparam int CODE_W    = 2;
  localparam int SLOT_W    = $clog2(SLOT_MAX);
  localparam int CODE_LSB  = 4;
  localparam int LEN_LSB   = CODE_LSB + SLOT_MAX * CODE_W;
  localparam int MODE_LSB  = LEN_LSB + SLOT_W;

  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_WAIT} seq_state_e;

  typedef struct packed {
    logic                                 seq_on;
    logic                                 single_trig;
    logic                                 busy_hold;
    logic [SLOT_W-1:0]                    last_slot;
    logic [SLOT_MAX-1:0][CODE_W-1:0]      codes;
  } seq_cfg_t;
endpackage

// File: rtl/adc_seq_cfg.sv
module adc_seq_cfg
  import adc_seq_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          pseudo_diff,
  input  logic                          wr_en,
  input  logic                          wr_ok,
  input  logic [CFG_W-1:CODE_LSB]       wr_word,
  output seq_cfg_t                      cfg
);
  logic [CFG_W-1:CODE_LSB] word_q;
  logic [SLOT_W-1:0]       len_f;
  logic [1:0]              mode_f;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                word_q <= '0;
    else if (wr_en && wr_ok)   word_q <= wr_word;
  end

  assign len_f  = word_q[LEN_LSB +: SLOT_W];
  assign mode_f = word_q[MODE_LSB +: 2];

  generate
    for (genvar s = 0; s < SLOT_MAX; s++) begin : g_code
      assign cfg.codes[s] = word_q[LEN_LSB - (s + 1) * CODE_W +: CODE_W];
    end
  endgenerate

  assign cfg.seq_on      = pseudo_diff && (len_f != '0);
  assign cfg.single_trig = cfg.seq_on && mode_f[1];
  assign cfg.busy_hold   = mode_f[1] && mode_f[0];
  assign cfg.last_slot   = len_f;

  // R10: the stored word only changes on a permitted write
  a_r10_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_ok) |=> $stable(word_q));
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
  import adc_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  seq_cfg_t          cfg,
  input  logic              conv_start,
  input  logic              conv_done,
  output logic [SLOT_W-1:0] slot,
  output logic              conv_req,
  output logic              busy,
  output logic              seq_done,
  output logic              wr_ok
);
  seq_state_e st_q;
  logic       last_hit;

  assign last_hit = (slot == cfg.last_slot);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      slot     <= '0;
      seq_done <= 1'b0;
    end else begin
      seq_done <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (conv_start) st_q <= ST_REQ;
        ST_REQ:  st_q <= ST_WAIT;
        ST_WAIT: if (conv_done) begin
          if (!cfg.seq_on) begin
            st_q <= ST_IDLE;
          end else if (last_hit) begin
            st_q     <= ST_IDLE;
            slot     <= '0;
            seq_done <= 1'b1;
          end else begin
            slot <= slot + 1'b1;
            st_q <= cfg.single_trig ? ST_REQ : ST_IDLE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign conv_req = (st_q == ST_REQ);
  assign busy     = (st_q == ST_WAIT) ||
                    (conv_req && cfg.single_trig && cfg.busy_hold && slot != '0);
  assign wr_ok    = (st_q == ST_IDLE) && (slot == '0);

  // R4: a request never lasts more than one clock
  a_r4_req_single: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req |=> !conv_req);
  // R8: end-of-list flag is a single pulse and leaves the index at slot 0
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |=> !seq_done);
  a_r8_done_slot0: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |-> slot == '0);
  // R7: hold-mode BUSY stays up until the last slot completes
  a_r7_hold_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cfg.single_trig && cfg.busy_hold && !(conv_done && last_hit)) |=> busy);
  // R9: a running conversion is not restarted by a new start
  a_r9_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !conv_done) |=> !conv_req);
endmodule

// File: rtl/adc_seq_chsel.sv
module adc_seq_chsel
  import adc_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  seq_cfg_t          cfg,
  input  logic [SLOT_W-1:0] slot,
  input  logic              busy,
  input  logic              conv_done,
  output logic [CODE_W-1:0] mux_sel
);
  always_comb begin
    mux_sel = cfg.codes[0];
    if (cfg.seq_on) begin
      for (int s = 1; s < SLOT_MAX; s++)
        if (slot == SLOT_W'(s)) mux_sel = cfg.codes[s];
    end
  end

  // R3: the selection holds for the whole conversion
  a_r3_mux_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !conv_done) |=> $stable(mux_sel));
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pseudo_diff,
  input  logic             cfg_wr,
  input  logic [15:0]      cfg_data,
  input  logic             conv_start,
  input  logic             conv_done,
  output logic [1:0]       mux_sel,
  output logic             conv_req,
  output logic             busy,
  output logic             seq_done
);
  seq_cfg_t          cfg;
  logic [SLOT_W-1:0] slot;
  logic              wr_ok;
  logic              unused_low;

  assign unused_low = ^cfg_data[CODE_LSB-1:0];

  adc_seq_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .pseudo_diff(pseudo_diff),
    .wr_en(cfg_wr), .wr_ok(wr_ok), .wr_word(cfg_data[CFG_W-1:CODE_LSB]),
    .cfg(cfg)
  );

  adc_seq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .cfg(cfg), .conv_start(conv_start),
    .conv_done(conv_done), .slot(slot), .conv_req(conv_req), .busy(busy),
    .seq_done(seq_done), .wr_ok(wr_ok)
  );

  adc_seq_chsel u_chsel (
    .clk(clk), .rst_n(rst_n), .cfg(cfg), .slot(slot), .busy(busy),
    .conv_done(conv_done), .mux_sel(mux_sel)
  );

  // R2: no end-of-list flag in single-channel mode
  a_r2_single_nodone: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg.seq_on && !$past(cfg.seq_on)) |-> !seq_done);
endmodule

// File: tb/adc_seq_ctrl_tb_top.sv
module adc_seq_ctrl_tb_top;
  localparam int LAT = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pseudo_diff = 1'b1;
  logic cfg_wr = 1'b0;
  logic [15:0] cfg_data = '0;
  logic conv_start = 1'b0;
  logic conv_done;
  logic [1:0] mux_sel;
  logic conv_req, busy, seq_done;

  int n_chk = 0;
  int n_err = 0;
  logic       rec_req [0:63];
  logic       rec_busy[0:63];
  logic       rec_done[0:63];
  logic [1:0] rec_mux [0:63];
  logic [LAT-1:0] stub_sr;

  always #10 clk = ~clk;

  adc_seq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .pseudo_diff(pseudo_diff), .cfg_wr(cfg_wr),
    .cfg_data(cfg_data), .conv_start(conv_start), .conv_done(conv_done),
    .mux_sel(mux_sel), .conv_req(conv_req), .busy(busy), .seq_done(seq_done)
  );

  // converter stub: done pulse LAT clocks after each request
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) stub_sr <= '0;
    else        stub_sr <= {stub_sr[LAT-2:0], conv_req};
  assign conv_done = stub_sr[LAT-1];

  task automatic chk(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_err++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic write_cfg(input logic [15:0] w);
    @(negedge clk); cfg_wr = 1'b1; cfg_data = w;
    @(negedge clk); cfg_wr = 1'b0;
  endtask

  // start edge is cycle 0; samples cycles 1..n; optional stray start at cycle extra
  task automatic capture(input int n, input int extra);
    @(negedge clk); conv_start = 1'b1;
    @(negedge clk); conv_start = 1'b0;
    for (int k = 1; k <= n; k++) begin
      rec_req[k] = conv_req; rec_busy[k] = busy;
      rec_done[k] = seq_done; rec_mux[k] = mux_sel;
      conv_start = (k == extra);
      @(negedge clk);
    end
    conv_start = 1'b0;
  endtask

  // trace from the requirements: request i at 1+4i, busy 2+4i..4+4i, done at 4*nreq+1
  task automatic verify(input string tag, input int n, input int nreq, input bit hold,
                        input bit fin, input logic [7:0] codes, input logic [1:0] end_mux);
    int bad_req = 0, bad_busy = 0, bad_done = 0, bad_mux = 0;
    for (int k = 1; k <= n; k++) begin
      bit er, eb, ed;
      int ph = (k - 1) % 4;
      int ix = (k - 1) / 4;
      er = (ph == 0) && (ix < nreq);
      if (hold) eb = (k >= 2) && (k <= 4 * nreq);
      else      eb = (ph != 0) && (ix < nreq);
      ed = fin && (k == 4 * nreq + 1);
      if (rec_req[k] != er)  bad_req++;
      if (rec_busy[k] != eb) bad_busy++;
      if (rec_done[k] != ed) bad_done++;
      if (er && rec_mux[k] != codes[2*ix +: 2]) bad_mux++;
    end
    chk({tag, " req timing R4"}, bad_req, 0);
    chk({tag, " busy shape R5/R6/R7"}, bad_busy, 0);
    chk({tag, " seq_done R8"}, bad_done, 0);
    chk({tag, " slot codes R3"}, bad_mux, 0);
    chk({tag, " final mux R8"}, rec_mux[n], end_mux);
  endtask

  task automatic t_reset;
    chk("R1 mux", mux_sel, 0);
    chk("R1 req", conv_req, 0);
    chk("R1 busy", busy, 0);
    chk("R1 done", seq_done, 0);
  endtask

  task automatic t_single;
    pseudo_diff = 1'b1;
    write_cfg(16'h0800);
    capture(8, 0); verify("R2 len00", 8, 1, 1'b0, 1'b0, 8'h02, 2'd2);
    capture(8, 0); verify("R2 len00 again", 8, 1, 1'b0, 1'b0, 8'h02, 2'd2);
  endtask

  task automatic t_not_pseudo;
    pseudo_diff = 1'b0;
    write_cfg(16'hFD80);
    capture(12, 0); verify("R2 pseudo low", 12, 1, 1'b0, 1'b0, 8'h03, 2'd3);
    pseudo_diff = 1'b1;
  endtask

  task automatic t_hold4;
    capture(20, 6); verify("R7 mode11 len4 R9", 20, 4, 1'b1, 1'b1, 8'h27, 2'd3);
  endtask

  task automatic t_pulse3;
    write_cfg(16'hA780);
    capture(16, 0); verify("R6 mode10 len3", 16, 3, 1'b0, 1'b1, 8'h2D, 2'd1);
  endtask

  task automatic t_per_slot;
    write_cfg(16'h1900);
    capture(8, 2); verify("R5 slot0 R9", 8, 1, 1'b0, 1'b0, 8'h02, 2'd1);
    write_cfg(16'h0000);
    @(negedge clk); chk("R10 write mid-list ignored", mux_sel, 1);
    capture(8, 0); verify("R5 slot1", 8, 1, 1'b0, 1'b1, 8'h01, 2'd2);
    write_cfg(16'h0000);
    @(negedge clk); chk("R10 idle write taken", mux_sel, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_single();
    t_not_pseudo();
    t_hold4();
    t_pulse3();
    t_per_slot();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule